// File: doc/BRIEF.md
# APB Down-Counting Interval Timer

A bank of independent 32-bit down counters behind a zero-wait-state APB slave. Each channel counts down by one on every clock while enabled. When its count has reached zero, the next clock either reloads the programmed load value (periodic mode) or wraps the count to all ones (free-running mode). That expiry latches a pending interrupt.

Each channel has a mask bit that gates its interrupt line and its masked status, but not its raw pending bit. Software acknowledges a channel by reading that channel's acknowledge register, or acknowledges every channel at once by reading a shared acknowledge register. A shared block after the channel slots returns the masked and raw pending bits of all channels as vectors, together with a constant identification word.

To start a channel, software first clears its enable bit, then writes the load value, then sets the enable bit again. The count takes the load value one clock after the enable is seen.

Top module: `apb_interval_timer`

## Requirements
- R1: Channel n occupies byte offsets n*0x14 to n*0x14+0x13, with load value at +0x00, live count at +0x04, control at +0x08, acknowledge at +0x0C and masked status (bit 0) at +0x10. Load value and control read back what was written, and control reads back only bits 2:0.
- R2: Control bit 0 is enable, bit 1 selects periodic reload (1) or free-running (0), and bit 2 masks the channel interrupt (1 = masked). All control bits reset to 0, and the count resets to 0.
- R3: One clock after the enable bit is seen going from 0 to 1, the count takes the load value. While enable is 0, the count holds its value.
- R4: While running, the count drops by one per clock. In periodic mode, the clock after the count is 0 reloads the load value and sets the raw pending bit, so the interrupt rises load+1 clocks after the count was loaded.
- R5: In free-running mode, the clock after the count is 0 loads 0xFFFF_FFFF and sets the raw pending bit.
- R6: The irq output and the masked status of a channel equal its raw pending bit gated by the inverse of its mask bit. The mask has no effect on the raw bit.
- R7: Reading a channel's acknowledge register returns 0 and clears that channel's raw pending bit.
- R8: Shared registers: masked status vector at 0xA0 (bit n = channel n), acknowledge-all at 0xA4 (a read returns 0 and clears every channel), raw status vector at 0xA8, and an identification word at 0xAC (default 0x3130_352A).
- R9: If a channel expires in the same clock as a read that acknowledges it, the pending bit stays set.
- R10: PREADY is always 1 and PSLVERR always 0. Unmapped addresses read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Timer and bus clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | NUM_CH | Per-channel masked interrupt |

## Verification
The critical collision is a counter expiring in the very clock edge that completes an acknowledge read of the same channel. The bench loads a short period and starts the read so that its access phase closes on the computed expiry edge. It then judges at the ports that the interrupt line is still high. A second acknowledge, timed between two expiries, must then bring the line low, which shows that the clear path itself works.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package: shared address map and control layout of the interval timer.
// Assumes byte addressing with word-aligned accesses.
package tmr_pkg;
    localparam int SLOT_BYTES = 'h14;
    localparam int OFF_LOAD   = 'h00;
    localparam int OFF_COUNT  = 'h04;
    localparam int OFF_CTRL   = 'h08;
    localparam int OFF_ACK    = 'h0C;
    localparam int OFF_STAT   = 'h10;
    localparam int G_MSTAT    = 'hA0;
    localparam int G_ACK      = 'hA4;
    localparam int G_RAW      = 'hA8;
    localparam int G_IDENT    = 'hAC;

    // Control register: bit2 mask, bit1 periodic, bit0 enable
    typedef struct packed {
        logic mask;
        logic periodic;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Module: tmr_counter
// Down counter with reload-on-enable, periodic or wrap-to-ones reload on
// expiry, and a latched raw pending bit. An expiry takes priority over a clear
// in the same clock. Assumes en/periodic/load come straight from registers.
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         periodic,
    input  logic [W-1:0] load,
    input  logic         clr,
    output logic [W-1:0] count,
    output logic         running,
    output logic         expire,
    output logic         raw
);
    logic en_q;

    assign running = en_q;
    assign expire  = en && en_q && (count == '0);

    // Count register: load on enable edge, decrement or reload while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en;
            if (en && !en_q) begin
                count <= load;
            end else if (en) begin
                if (count == '0) count <= periodic ? load : '1;
                else             count <= count - W'(1);
            end
        end
    end

    // Pending bit: set on expiry, cleared by acknowledge unless expiring
    always_ff @(posedge clk) begin
        if (!rst_n)      raw <= 1'b0;
        else if (expire) raw <= 1'b1;
        else if (clr)    raw <= 1'b0;
    end
endmodule

// File: rtl/tmr_slot.sv
`timescale 1ns/1ps
// Module: tmr_slot
// One channel's register slot at byte base BASE: load and control registers,
// local decode, acknowledge-on-read and read mux. Assumes BASE + slot size
// stays below the shared register block and inside the address range.
module tmr_slot
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int BASE   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              ack_all,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              raw,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] load_o,
    output logic              en_o,
    output logic              periodic_o,
    output logic              running_o,
    output logic              expire_o,
    output logic              clr_o
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic [DATA_W-1:0] load_r;
    ctrl_t             ctrl_r;
    logic              clr;

    assign off = paddr - BASE_A;
    assign hit = off < ADDR_W'(SLOT_BYTES);
    assign clr = ack_all || (acc_rd && hit && off == ADDR_W'(OFF_ACK));

    // Software registers: load value and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_r <= '0;
            ctrl_r <= '0;
        end else if (acc_wr && hit) begin
            if (off == ADDR_W'(OFF_LOAD)) load_r <= pwdata;
            if (off == ADDR_W'(OFF_CTRL)) ctrl_r <= ctrl_t'(pwdata[2:0]);
        end
    end

    tmr_counter #(.W(DATA_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctrl_r.enable),
        .periodic (ctrl_r.periodic),
        .load     (load_r),
        .clr      (clr),
        .count    (count_o),
        .running  (running_o),
        .expire   (expire_o),
        .raw      (raw)
    );

    assign irq        = raw && !ctrl_r.mask;
    assign load_o     = load_r;
    assign en_o       = ctrl_r.enable;
    assign periodic_o = ctrl_r.periodic;
    assign clr_o      = clr;

    // Read mux: slot-local registers, zero outside the slot
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (off)
                ADDR_W'(OFF_LOAD):  rdata = load_r;
                ADDR_W'(OFF_COUNT): rdata = count_o;
                ADDR_W'(OFF_CTRL):  rdata = DATA_W'(ctrl_r);
                ADDR_W'(OFF_STAT):  rdata = DATA_W'(irq);
                default:            rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/apb_interval_timer.sv
`timescale 1ns/1ps
// Module: apb_interval_timer
// Top: APB zero-wait slave over NUM_CH timer slots plus a shared status and
// acknowledge block. Assumes NUM_CH * 0x14 <= 0xA0 and NUM_CH <= DATA_W.
module apb_interval_timer
    import tmr_pkg::*;
#(
    parameter int          NUM_CH  = 2,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 8,
    parameter logic [31:0] IDENT   = 32'h3130_352A
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_CH-1:0] irq
);
    logic acc_wr, acc_rd, ack_all;

    logic [NUM_CH-1:0][DATA_W-1:0] slot_rd;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_cnt;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_load;
    logic [NUM_CH-1:0]             ch_raw, ch_en, ch_per, ch_run, ch_exp, ch_clr;
    logic [DATA_W-1:0]             glb_rd;

    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign ack_all = acc_rd && (paddr == ADDR_W'(G_ACK));
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr_slot #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .BASE   (i * SLOT_BYTES)
        ) slot_i (
            .clk        (pclk),
            .rst_n      (presetn),
            .acc_wr     (acc_wr),
            .acc_rd     (acc_rd),
            .paddr      (paddr),
            .pwdata     (pwdata),
            .ack_all    (ack_all),
            .rdata      (slot_rd[i]),
            .irq        (irq[i]),
            .raw        (ch_raw[i]),
            .count_o    (ch_cnt[i]),
            .load_o     (ch_load[i]),
            .en_o       (ch_en[i]),
            .periodic_o (ch_per[i]),
            .running_o  (ch_run[i]),
            .expire_o   (ch_exp[i]),
            .clr_o      (ch_clr[i])
        );
    end

    // Shared block read decode
    always_comb begin
        case (paddr)
            ADDR_W'(G_MSTAT): glb_rd = DATA_W'(irq);
            ADDR_W'(G_RAW):   glb_rd = DATA_W'(ch_raw);
            ADDR_W'(G_IDENT): glb_rd = DATA_W'(IDENT);
            default:          glb_rd = '0;
        endcase
    end

    // Read data: OR of the slot muxes (each zero off-slot) and shared block
    always_comb begin
        prdata = glb_rd;
        for (int i = 0; i < NUM_CH; i++) prdata = prdata | slot_rd[i];
    end
endmodule

// File: rtl/tmr_checker.sv
`timescale 1ns/1ps
// Module: tmr_checker
// Temporal checks on every channel of apb_interval_timer, bound to the top.
module tmr_checker #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ack_all,
    input logic [NUM_CH-1:0]                en,
    input logic [NUM_CH-1:0]                per,
    input logic [NUM_CH-1:0]                run,
    input logic [NUM_CH-1:0]                expire,
    input logic [NUM_CH-1:0]                clr,
    input logic [NUM_CH-1:0]                raw,
    input logic [NUM_CH-1:0][DATA_W-1:0]    cnt,
    input logic [NUM_CH-1:0][DATA_W-1:0]    load
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && !run[i]) |=> cnt[i] == $past(load[i])); // R3
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |=> $stable(cnt[i])); // R3
        AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (en[i] && run[i] && cnt[i] != '0) |=> cnt[i] == $past(cnt[i]) - DATA_W'(1)); // R4
        AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && per[i]) |=> (cnt[i] == $past(load[i])) && raw[i]); // R4
        AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && !per[i]) |=> (cnt[i] == '1) && raw[i]); // R5
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !expire[i]) |=> !raw[i]); // R7
        AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[i] && clr[i]) |=> raw[i]); // R9
    end

    AST_ACK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_all && expire == '0) |=> raw == '0); // R8
endmodule

bind apb_interval_timer tmr_checker #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
    .clk     (pclk),
    .rst_n   (presetn),
    .ack_all (ack_all),
    .en      (ch_en),
    .per     (ch_per),
    .run     (ch_run),
    .expire  (ch_exp),
    .clr     (ch_clr),
    .raw     (ch_raw),
    .cnt     (ch_cnt),
    .load    (ch_load)
);

// File: tb/apb_interval_timer_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for apb_interval_timer with two channels.
module apb_interval_timer_tb_top;
    localparam int NUM_CH = 2;
    localparam int DW     = 32;
    localparam int AW     = 8;
    localparam logic [31:0] IDENT_EXP = 32'h3130_352A;

    logic          pclk = 1'b0;
    logic          presetn;
    logic          psel, penable, pwrite;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwdata, prdata;
    logic          pready, pslverr;
    logic [NUM_CH-1:0] irq;

    int n_tests = 0;
    int n_fail  = 0;
    int bus_bad = 0;

    always #10 pclk = ~pclk;

    apb_interval_timer #(.NUM_CH(NUM_CH), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
        .prdata, .pready, .pslverr, .irq
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a negedge; write completes at the second following posedge
    task automatic apb_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Called at a negedge; samples in the access phase, side effects at its end
    task automatic apb_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        if (pready !== 1'b1 || pslverr !== 1'b0) bus_bad++;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        apb_read(8'h08, d); chk("R2 control reset", d, 0);
        apb_read(8'h04, d); chk("R2 count reset", d, 0);
        apb_read(8'hA8, d); chk("R8 raw reset", d, 0);
        apb_read(8'hAC, d); chk("R8 ident word", d, IDENT_EXP);
        chk("R6 irq reset", 32'(irq), 0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        apb_write(8'h00, 32'd5);
        apb_write(8'h08, 32'h3);              // periodic, enabled, unmasked
        repeat (6) @(negedge pclk);
        chk("R4 no irq before load+1 clocks", 32'(irq[0]), 0);
        @(negedge pclk);
        chk("R4 irq at load+1 clocks (R3 load)", 32'(irq[0]), 1);
        apb_read(8'h10, d); chk("R1 slot status", d, 1);
        apb_read(8'hA0, d); chk("R8 masked vector", d, 1);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        apb_write(8'h08, 32'h2);              // disable, keep periodic
        apb_read(8'h0C, d); chk("R7 ack returns 0", d, 0);
        apb_read(8'h10, d); chk("R7 status cleared", d, 0);
        chk("R7 irq cleared", 32'(irq[0]), 0);
    endtask

    task automatic t_hold();
        logic [31:0] a, b;
        apb_read(8'h04, a);
        repeat (10) @(negedge pclk);
        apb_read(8'h04, b);
        chk("R3 count holds while disabled", b, a);
        apb_read(8'h00, a); chk("R1 load readback", a, 5);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        apb_write(8'h00, 32'd3);
        apb_write(8'h08, 32'h7);              // masked, periodic, enabled
        repeat (20) @(negedge pclk);
        chk("R6 masked irq low", 32'(irq[0]), 0);
        apb_read(8'hA0, d); chk("R6 masked vector", d, 0);
        apb_read(8'hA8, d); chk("R6 raw unaffected", d, 1);
        apb_read(8'h10, d); chk("R6 slot status masked", d, 0);
        apb_read(8'h08, d); chk("R1 control readback", d, 7);
    endtask

    task automatic t_free();
        logic [31:0] d;
        apb_write(8'h14, 32'd2);
        apb_write(8'h1C, 32'h1);              // free-running, enabled
        repeat (3) @(negedge pclk);
        apb_read(8'h18, d); chk("R5 wrap to all ones", d, 32'hFFFF_FFFF);
        chk("R5 free-running irq", 32'(irq[1]), 1);
        apb_write(8'h1C, 32'hFFFF_FFF9);
        apb_read(8'h1C, d); chk("R1 control bits 2:0 only", d, 1);
        apb_read(8'h14, d); chk("R1 slot spacing load", d, 2);
    endtask

    task automatic t_global();
        logic [31:0] d;
        apb_write(8'h08, 32'h6);              // stop channel 0
        apb_read(8'hA8, d); chk("R8 raw vector both", d, 3);
        apb_read(8'hA4, d); chk("R8 ack-all returns 0", d, 0);
        apb_read(8'hA8, d); chk("R8 ack-all clears", d, 0);
        chk("R8 irq after ack-all", 32'(irq), 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        apb_write(8'h00, 32'd4);
        apb_write(8'h08, 32'h3);              // enable: count=4 next clock
        repeat (4) @(negedge pclk);
        apb_read(8'h0C, d);                   // completes on the expiry edge
        chk("R9 expiry wins over ack", 32'(irq[0]), 1);
        apb_read(8'h0C, d);                   // completes between expiries
        chk("R7 ack between expiries", 32'(irq[0]), 0);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        apb_write(8'h30, 32'hDEAD_BEEF);
        apb_read(8'h30, d); chk("R10 unmapped reads zero", d, 0);
        apb_read(8'hB4, d); chk("R10 above shared block", d, 0);
        apb_read(8'h14, d); chk("R10 unmapped write ignored", d, 2);
        chk("R10 pready/pslverr", 32'(bus_bad), 0);
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        paddr = '0; pwdata = '0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset();
        t_periodic();
        t_ack();
        t_hold();
        t_mask();
        t_free();
        t_global();
        t_collide();
        t_bus();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule